// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit performs one decimal operation per request on a byte that holds two packed BCD digits. The operation can be an add with extend, a subtract with extend or a negate with extend. The caller presents an operation code, two operand bytes and the incoming extend and zero flags, then pulses `valid_i`. One clock later the unit registers the decimal result and the new flags, and pulses `done_o` for one cycle.

The zero flag is built for loops over multi-byte decimal numbers. A non-zero result byte clears it. A zero result byte passes the incoming value through unchanged. Software sets the flag once before the least significant byte and feeds `x_o` and `z_o` back as `x_i` and `z_i` for each following byte. At the end of the loop the flag still reads set only if every byte of the number was zero.

Digits above 9 are not rejected. They pass through the same per-digit correction, which gives a fixed result for every input pattern.

Top module: `bcd_byte_alu`

## Requirements
- R1: With op code 0 (add), the result is source + destination + `x_i`, computed in decimal modulo 100 for valid packed digits.
- R2: With op code 1 (subtract), the result is destination − source − `x_i` in decimal. A negative difference wraps by adding 100.
- R3: With op code 2 (negate), the result is 0 − destination − `x_i` in decimal. A negative value wraps by adding 100, and the source byte is ignored.
- R4: `c_o` is 1 when the operation produces a decimal carry out of the upper digit (add) or a decimal borrow (subtract, negate), and 0 otherwise. `x_o` always equals `c_o`.
- R5: `z_o` is 0 when the result byte is non-zero and equals `z_i` when the result byte is zero. A zero `z_i` therefore always gives a zero `z_o`.
- R6: `n_o` and `v_o` are always 0.
- R7: `done_o` is 1 exactly in the cycle after a cycle with `valid_i` high. The result and flag outputs change only in the cycle after `valid_i` and otherwise hold their values.
- R8: While reset is asserted and directly after it, every output is 0.
- R9: Op code 3 behaves exactly like op code 0 (add).
- R10: Operands holding digits 10 to 15 give the same outputs every time the same inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 add, 1 subtract, 2 negate, 3 add |
| src_i | input | 8 | Source packed BCD byte |
| dst_i | input | 8 | Destination packed BCD byte |
| x_i | input | 1 | Incoming extend flag |
| z_i | input | 1 | Incoming zero flag |
| result_o | output | 8 | Registered packed BCD result |
| x_o | output | 1 | Extend flag, equal to carry |
| z_o | output | 1 | Sticky zero flag |
| c_o | output | 1 | Decimal carry or borrow |
| n_o | output | 1 | Negative flag, held at 0 |
| v_o | output | 1 | Overflow flag, held at 0 |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a zero result byte arriving while the incoming zero flag is set. Random digits rarely produce it, because it needs inputs such as 50 + 50 with no extend, the negate of 00 with no extend, or equal operands in a subtract.

The bench therefore runs directed multi-byte chains, feeding `x_o` and `z_o` back into the next request. One chain is all zero, one has a single non-zero byte in the middle, and one produces a zero byte through a carry. The chains check that the flag survives zero bytes and never comes back once it has been cleared. Random add, subtract and negate requests with both flag inputs then cover the general digit and carry arithmetic.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_NEG  = 2'd2,
    OP_ADD2 = 2'd3
  } bcd_op_e;
endpackage

// File: rtl/bcd_digit_step.sv
// One decimal digit: binary add or subtract of two nibbles with carry/borrow in,
// followed by a +6 / -6 correction.
module bcd_digit_step (
  input  logic       sub_i,
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  output logic [3:0] d_o,
  output logic       cout_o
);
  logic [4:0] raw;

  always_comb begin
    if (!sub_i) begin
      raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0, cin_i};
      if (raw > 5'd9) begin
        d_o    = raw[3:0] + 4'd6;
        cout_o = 1'b1;
      end else begin
        d_o    = raw[3:0];
        cout_o = 1'b0;
      end
    end else begin
      raw = {1'b0, a_i} - {1'b0, b_i} - {4'b0, cin_i};
      if (raw[4]) begin
        d_o    = raw[3:0] - 4'd6;
        cout_o = 1'b1;
      end else begin
        d_o    = raw[3:0];
        cout_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_core.sv
// Combinational packed-decimal datapath: operand steering plus a ripple of digit steps.
module bcd_core
  import bcd_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         xin_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  logic [W-1:0]    lhs;
  logic [W-1:0]    rhs;
  logic            is_sub;
  logic [DIGITS:0] chain;

  always_comb begin
    case (bcd_op_e'(op_i))
      OP_SUB: begin
        lhs    = dst_i;
        rhs    = src_i;
        is_sub = 1'b1;
      end
      OP_NEG: begin
        lhs    = '0;
        rhs    = dst_i;
        is_sub = 1'b1;
      end
      default: begin
        lhs    = src_i;
        rhs    = dst_i;
        is_sub = 1'b0;
      end
    endcase
  end

  assign chain[0] = xin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_step u_step (
      .sub_i  (is_sub),
      .a_i    (lhs[4*g +: 4]),
      .b_i    (rhs[4*g +: 4]),
      .cin_i  (chain[g]),
      .d_o    (res_o[4*g +: 4]),
      .cout_o (chain[g+1])
    );
  end

  assign carry_o = chain[DIGITS];
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         x_i,
  input  logic         z_i,
  output logic [W-1:0] result_o,
  output logic         x_o,
  output logic         z_o,
  output logic         c_o,
  output logic         n_o,
  output logic         v_o,
  output logic         done_o
);
  logic [W-1:0] sum;
  logic         carry;
  logic [W-1:0] res_q;
  logic         x_q;
  logic         z_q;
  logic         c_q;
  logic         done_q;
  logic         z_d;

  bcd_core #(.DIGITS(DIGITS)) u_core (
    .op_i    (op_i),
    .src_i   (src_i),
    .dst_i   (dst_i),
    .xin_i   (x_i),
    .res_o   (sum),
    .carry_o (carry)
  );

  // Sticky zero: only a non-zero byte can clear it, nothing sets it.
  always_comb begin
    z_d = z_i & (sum == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      x_q   <= 1'b0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else if (valid_i) begin
      res_q <= sum;
      x_q   <= carry;
      z_q   <= z_d;
      c_q   <= carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= valid_i;
  end

  assign result_o = res_q;
  assign x_o      = x_q;
  assign z_o      = z_q;
  assign c_o      = c_q;
  assign n_o      = 1'b0;
  assign v_o      = 1'b0;
  assign done_o   = done_q;
endmodule

// File: rtl/bcd_byte_alu_chk.sv
module bcd_byte_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic         z_i,
  input logic [W-1:0] result_o,
  input logic         x_o,
  input logic         z_o,
  input logic         c_o,
  input logic         done_o
);
  p_done_after_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);

  p_no_stray_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);

  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(result_o) && $stable(z_o) && $stable(c_o)));

  p_x_tracks_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (x_o == c_o));

  p_zero_never_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !z_i) |=> !z_o);

  p_zero_follows_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && z_i) |=> (z_o == (result_o == '0)));
endmodule

bind bcd_byte_alu bcd_byte_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .z_i      (z_i),
  .result_o (result_o),
  .x_o      (x_o),
  .z_o      (z_o),
  .c_o      (c_o),
  .done_o   (done_o)
);

// File: tb/sim_bcd_byte_alu.sv
module sim_bcd_byte_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       valid_i;
  logic [1:0] op_i;
  logic [7:0] src_i;
  logic [7:0] dst_i;
  logic       x_i;
  logic       z_i;
  logic [7:0] result_o;
  logic       x_o;
  logic       z_o;
  logic       c_o;
  logic       n_o;
  logic       v_o;
  logic       done_o;

  int checks;
  int fails;
  logic [7:0] keep_res;
  logic       keep_c;
  logic       keep_z;

  bcd_byte_alu u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .x_i(x_i), .z_i(z_i),
    .result_o(result_o), .x_o(x_o), .z_o(z_o), .c_o(c_o),
    .n_o(n_o), .v_o(v_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int dec(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(input int v);
    logic [3:0] hi;
    logic [3:0] lo;
    hi = 4'(v / 10);
    lo = 4'(v % 10);
    return {hi, lo};
  endfunction

  // Expected {carry, result} from the decimal meaning of each operation.
  function automatic logic [8:0] model(input logic [1:0] op, input logic [7:0] s,
                                       input logic [7:0] d, input logic x);
    int v;
    logic c;
    case (op)
      2'd1:    v = dec(d) - dec(s) - int'(x);
      2'd2:    v = 0 - dec(d) - int'(x);
      default: v = dec(s) + dec(d) + int'(x);
    endcase
    c = 1'b0;
    if (v < 0)   begin v = v + 100; c = 1'b1; end
    if (v > 99)  begin v = v - 100; c = 1'b1; end
    return {c, enc(v)};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Issue one request and check every output in the cycle after.
  task automatic do_op(input logic [1:0] op, input logic [7:0] s, input logic [7:0] d,
                       input logic x, input logic z, input string req);
    logic [8:0] e;
    logic       ez;
    e  = model(op, s, d, x);
    ez = z & (e[7:0] == 8'h00);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; src_i = s; dst_i = d; x_i = x; z_i = z;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, "result", int'(result_o), int'(e[7:0]));
    check("R4", "carry", int'(c_o), int'(e[8]));
    check("R4", "x=c", int'(x_o), int'(e[8]));
    check("R5", "zero", int'(z_o), int'(ez));
    check("R6", "n/v", int'({n_o, v_o}), 0);
    check("R7", "done", int'(done_o), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    valid_i = 0; op_i = 0; src_i = 0; dst_i = 0; x_i = 0; z_i = 0;
    rst_n = 0;
    #(CLK_PERIOD * 2 + 1);
    check("R8", "reset outputs",
          int'({result_o, x_o, z_o, c_o, n_o, v_o, done_o}), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R8", "after reset",
          int'({result_o, x_o, z_o, c_o, done_o}), 0);

    // Directed corners
    do_op(2'd0, 8'h45, 8'h38, 1'b0, 1'b1, "R1");   // 83
    do_op(2'd0, 8'h99, 8'h99, 1'b1, 1'b1, "R1");   // 99 carry
    do_op(2'd0, 8'h50, 8'h50, 1'b0, 1'b1, "R1");   // 00 carry, z kept
    do_op(2'd1, 8'h38, 8'h45, 1'b0, 1'b1, "R2");   // 07
    do_op(2'd1, 8'h01, 8'h00, 1'b0, 1'b1, "R2");   // 99 borrow
    do_op(2'd1, 8'h45, 8'h45, 1'b1, 1'b0, "R2");   // 99 borrow
    do_op(2'd2, 8'h77, 8'h00, 1'b0, 1'b1, "R3");   // 00 no borrow
    do_op(2'd2, 8'h00, 8'h00, 1'b1, 1'b1, "R3");   // 99 borrow
    do_op(2'd2, 8'h12, 8'h37, 1'b0, 1'b1, "R3");   // 63 borrow
    do_op(2'd3, 8'h27, 8'h36, 1'b1, 1'b1, "R9");   // 64

    // R7: idle cycles leave outputs held and done low
    keep_res = result_o; keep_c = c_o; keep_z = z_o;
    @(negedge clk);
    src_i = 8'h11; dst_i = 8'h22; op_i = 2'd1;
    @(negedge clk);
    check("R7", "done pulse ends", int'(done_o), 0);
    check("R7", "result held", int'({result_o, c_o, z_o}), int'({keep_res, keep_c, keep_z}));

    // R5 chains: flags fed back byte after byte
    begin
      logic [7:0] bytes_a [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
      logic [7:0] bytes_b [4] = '{8'h00, 8'h00, 8'h05, 8'h00};
      logic xx, zz;
      xx = 0; zz = 1;
      for (int i = 0; i < 4; i++) begin
        do_op(2'd0, bytes_a[i], 8'h00, xx, zz, "R5");
        xx = x_o; zz = z_o;
      end
      check("R5", "all-zero chain", int'(zz), 1);
      xx = 0; zz = 1;
      for (int i = 0; i < 4; i++) begin
        do_op(2'd2, 8'h00, bytes_b[i], xx, zz, "R5");
        xx = x_o; zz = z_o;
      end
      check("R5", "non-zero chain", int'(zz), 0);
      xx = 0; zz = 1;
      do_op(2'd0, 8'h50, 8'h50, xx, zz, "R5");
      xx = x_o; zz = z_o;
      do_op(2'd0, 8'h00, 8'h98, xx, zz, "R5");
      check("R5", "carry chain", int'(z_o), 0);
    end

    // R10: non-decimal digits repeat identically
    begin
      logic [7:0] r1;
      logic [2:0] f1;
      for (int op = 0; op < 3; op++) begin
        @(negedge clk);
        valid_i = 1; op_i = 2'(op); src_i = 8'hFA; dst_i = 8'hCB; x_i = 1; z_i = 1;
        @(negedge clk); valid_i = 0;
        r1 = result_o; f1 = {x_o, z_o, c_o};
        @(negedge clk); valid_i = 1;
        @(negedge clk); valid_i = 0;
        check("R10", "repeatable", int'({result_o, x_o, z_o, c_o}), int'({r1, f1}));
      end
    end

    // Random valid decimal operands
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      do_op(op, enc(int'($urandom % 100)), enc(int'($urandom % 100)),
            1'($urandom % 2), 1'($urandom % 2),
            op == 2'd0 ? "R1" : op == 2'd1 ? "R2" : op == 2'd2 ? "R3" : "R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule